// File: doc/BRIEF.md
# Splittable Performance Counter Bank

This block holds a bank of physical event counters behind a 64-bit register port. Each physical counter counts as one 32-bit value, or is divided into two independent 16-bit halves, so the bank offers twice as many logical counters as physical ones. One event input exists per logical counter. While the unit is enabled, each asserted event input adds one to its counter on every clock.

A write to a counter does not touch the running count. It goes into a per-counter holding latch and marks that counter pending. The control register carries a global enable bit and one split bit per physical counter. Any write of the control register with the enable bit set copies every pending latch into its running counter, then clears the pending marks. Clearing the enable bit freezes all counts. Software therefore stages new counter values while the unit runs or sits idle, and commits them together with a single control write.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset the control register and every logical counter read as zero, so every physical counter starts in 32-bit mode and the unit is disabled.
- R2: Register data sits in bus bits 63:32. Bits 31:0 are ignored on write and read as zero. Address 0..3 selects logical counters 0..3, address 4..7 selects logical counters 4..7, and address 8 selects the control register. In the control register, bit 0 is enable and bit 1+p is the split bit of physical counter p. The control register reads back as written.
- R3: A counter write loads only the holding latch and marks the counter pending. While it is pending, a read returns the latched value and the running count does not show.
- R4: A control write with enable set, whether or not the unit is already enabled, loads every pending latch into its running counter and clears all pending marks.
- R5: While enabled, logical counter n (n<4) increments by one per clock in which event input n is high, and no other counter moves.
- R6: With enable clear, no counter moves whatever the event inputs do, and all counts are held.
- R7: In 32-bit mode a counter wraps from 0xFFFFFFFF to 0.
- R8: In split mode, logical counter n<4 is the upper half of physical n and logical counter n+4 is the lower half, counted by event n+4. Each half wraps from 0xFFFF to 0 with no carry into the other half.
- R9: A 16-bit logical write replaces only its own half in the latch and keeps the current visible value of the other half.
- R10: In 32-bit mode logical counters 4..7 read zero, writes to them are ignored, and event inputs 4..7 have no effect.
- R11: A counter with no pending write reads its running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (logical counter 0..7, control 8) |
| reg_wdata | input | 64 | Write data, payload in bits 63:32 |
| reg_rdata | output | 64 | Combinational read data for reg_addr, payload in bits 63:32 |
| evt | input | 8 | Event inputs, one per logical counter |

## Verification
A register write takes effect at the clock edge where reg_we is high. Because reads are combinational, the written or committed value is visible on reg_rdata from the following cycle. An event held high across N rising edges adds exactly N to its counter. All stimulus changes on the falling edge, and reads are sampled one time unit after a falling edge, once every register has settled. Expected counts therefore follow from the number of rising edges each event was held high.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;

   // Kind of latch update a physical slice receives in one cycle
   typedef enum logic [1:0] {
      WR_NONE = 2'd0,
      WR_FULL = 2'd1,
      WR_HI   = 2'd2,
      WR_LO   = 2'd3
   } wr_kind_e;

   localparam int unsigned BUS_W   = 64;
   localparam int unsigned FIELD_W = 32;
   localparam int unsigned FIELD_LSB = BUS_W - FIELD_W;

endpackage

// File: rtl/perf_ctr_ctrl.sv
module perf_ctr_ctrl #(
   parameter int unsigned NUM_PHYS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [NUM_PHYS:0]   wbits,
   output logic                run,
   output logic [NUM_PHYS-1:0] split,
   output logic                commit,
   output logic [NUM_PHYS:0]   ctrl_view
);

   logic [NUM_PHYS:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (we) begin
         ctrl_q <= wbits;
      end
   end

   assign run       = ctrl_q[0];
   assign split     = ctrl_q[NUM_PHYS:1];
   assign commit    = we && wbits[0];
   assign ctrl_view = ctrl_q;

   // R2
   ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (ctrl_view == $past(wbits)));

   // R2
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(ctrl_view));

endmodule

// File: rtl/perf_ctr_decode.sv
module perf_ctr_decode
   import perf_ctr_pkg::*;
#(
   parameter int unsigned NUM_PHYS = 4,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [NUM_PHYS-1:0] split,
   output wr_kind_e            wr_kind [NUM_PHYS],
   output logic                ctrl_we
);

   localparam int unsigned LOG_N     = 2 * NUM_PHYS;
   localparam int unsigned CTRL_ADDR = LOG_N;

   assign ctrl_we = we && (addr == ADDR_W'(CTRL_ADDR));

   for (genvar p = 0; p < NUM_PHYS; p++) begin : g_dec
      logic hit_up;
      logic hit_lo;
      assign hit_up = we && (addr == ADDR_W'(p));
      assign hit_lo = we && (addr == ADDR_W'(p + NUM_PHYS));

      always_comb begin
         wr_kind[p] = WR_NONE;
         if (hit_up) begin
            wr_kind[p] = split[p] ? WR_HI : WR_FULL;
         end else if (hit_lo && split[p]) begin
            wr_kind[p] = WR_LO;
         end
      end
   end

endmodule

// File: rtl/perf_ctr_slice.sv
module perf_ctr_slice
   import perf_ctr_pkg::*;
#(
   parameter int unsigned HALF_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  split,
   input  logic                  ev_hi,
   input  logic                  ev_lo,
   input  wr_kind_e              wr_kind,
   input  logic [2*HALF_W-1:0]   wr_val,
   input  logic                  commit,
   output logic [2*HALF_W-1:0]   view
);

   localparam int unsigned FULL_W = 2 * HALF_W;

   logic [FULL_W-1:0] live_q, live_d;
   logic [FULL_W-1:0] latch_q, latch_d;
   logic              pend_q;
   logic              take;

   assign view = pend_q ? latch_q : live_q;
   assign take = commit && pend_q;

   always_comb begin
      latch_d = latch_q;
      unique case (wr_kind)
         WR_FULL: latch_d = wr_val;
         WR_HI:   latch_d = {wr_val[HALF_W-1:0], view[HALF_W-1:0]};
         WR_LO:   latch_d = {view[FULL_W-1:HALF_W], wr_val[HALF_W-1:0]};
         default: latch_d = latch_q;
      endcase
   end

   always_comb begin
      live_d = live_q;
      if (take) begin
         live_d = latch_q;
      end else if (run) begin
         if (split) begin
            live_d[FULL_W-1:HALF_W] = live_q[FULL_W-1:HALF_W] + HALF_W'(ev_hi);
            live_d[HALF_W-1:0]      = live_q[HALF_W-1:0] + HALF_W'(ev_lo);
         end else begin
            live_d = live_q + FULL_W'(ev_hi);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q  <= '0;
         latch_q <= '0;
         pend_q  <= 1'b0;
      end else begin
         live_q  <= live_d;
         latch_q <= latch_d;
         if (commit) begin
            pend_q <= 1'b0;
         end else if (wr_kind != WR_NONE) begin
            pend_q <= 1'b1;
         end
      end
   end

   // R4
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !pend_q);

   // R3
   wr_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind != WR_NONE && !commit) |=> (pend_q && view == $past(latch_d)));

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !take) |=> $stable(live_q));

   // R7
   wrap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !split && !take && ev_hi && live_q == {FULL_W{1'b1}}) |=> (live_q == '0));

   // R8
   no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && split && !take && !ev_hi) |=> $stable(live_q[FULL_W-1:HALF_W]));

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
   import perf_ctr_pkg::*;
#(
   parameter int unsigned NUM_PHYS = 4,
   parameter int unsigned HALF_W   = 16,
   parameter int unsigned ADDR_W   = $clog2(2 * NUM_PHYS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_we,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic [BUS_W-1:0]        reg_wdata,
   output logic [BUS_W-1:0]        reg_rdata,
   input  logic [2*NUM_PHYS-1:0]   evt
);

   localparam int unsigned FULL_W    = 2 * HALF_W;
   localparam int unsigned LOG_N     = 2 * NUM_PHYS;
   localparam int unsigned CTRL_ADDR = LOG_N;

   if (NUM_PHYS < 1) begin : g_bad_phys
      $error("NUM_PHYS must be at least 1");
   end
   if (FULL_W > FIELD_W || HALF_W < 1) begin : g_bad_width
      $error("2*HALF_W must fit the 32-bit register field");
   end
   if (NUM_PHYS + 1 > FIELD_W) begin : g_bad_ctrl
      $error("control bits exceed the register field");
   end
   if ((1 << ADDR_W) < LOG_N + 1) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [FIELD_W-1:0]  wfield;
   logic                run;
   logic                commit;
   logic                ctrl_we;
   logic [NUM_PHYS-1:0] split;
   logic [NUM_PHYS:0]   ctrl_view;
   wr_kind_e            wr_kind [NUM_PHYS];
   logic [FULL_W-1:0]   view [NUM_PHYS];
   logic [FIELD_W-1:0]  rfield;
   logic                unused_low;

   assign wfield     = reg_wdata[BUS_W-1:FIELD_LSB];
   assign unused_low = ^reg_wdata[FIELD_LSB-1:0];

   perf_ctr_ctrl #(.NUM_PHYS(NUM_PHYS)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (ctrl_we),
      .wbits     (wfield[NUM_PHYS:0]),
      .run       (run),
      .split     (split),
      .commit    (commit),
      .ctrl_view (ctrl_view)
   );

   perf_ctr_decode #(.NUM_PHYS(NUM_PHYS), .ADDR_W(ADDR_W)) u_dec (
      .we      (reg_we),
      .addr    (reg_addr),
      .split   (split),
      .wr_kind (wr_kind),
      .ctrl_we (ctrl_we)
   );

   for (genvar p = 0; p < NUM_PHYS; p++) begin : g_slice
      perf_ctr_slice #(.HALF_W(HALF_W)) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (run),
         .split   (split[p]),
         .ev_hi   (evt[p]),
         .ev_lo   (evt[p + NUM_PHYS]),
         .wr_kind (wr_kind[p]),
         .wr_val  (wfield[FULL_W-1:0]),
         .commit  (commit),
         .view    (view[p])
      );
   end

   always_comb begin
      rfield = '0;
      if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
         rfield[NUM_PHYS:0] = ctrl_view;
      end
      for (int p = 0; p < NUM_PHYS; p++) begin
         if (reg_addr == ADDR_W'(p)) begin
            if (split[p]) begin
               rfield[HALF_W-1:0] = view[p][FULL_W-1:HALF_W];
            end else begin
               rfield[FULL_W-1:0] = view[p];
            end
         end else if (reg_addr == ADDR_W'(p + NUM_PHYS)) begin
            if (split[p]) begin
               rfield[HALF_W-1:0] = view[p][HALF_W-1:0];
            end
         end
      end
   end

   assign reg_rdata = {rfield, {FIELD_LSB{1'b0}}};

   // R2
   low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (reg_rdata[FIELD_LSB-1:0] == '0));

endmodule

// File: tb/perf_ctr_bank_tb.sv
module perf_ctr_bank_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] A_CTRL = 4'd8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [7:0]  evt = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   perf_ctr_bank u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt       (evt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] v);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_addr  = a;
      reg_wdata = {v, 32'hDEAD_BEEF};
      @(posedge clk);
      @(negedge clk);
      reg_we    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, reg_rdata, {exp, 32'h0});
   endtask

   task automatic pulse(input logic [7:0] m, input int n);
      @(negedge clk);
      evt = m;
      repeat (n) @(posedge clk);
      @(negedge clk);
      evt = '0;
   endtask

   task automatic t_reset();
      rd_chk("R1 ctrl", A_CTRL, 32'h0);
      for (int i = 0; i < 8; i++) rd_chk("R1 counter", 4'(i), 32'h0);
   endtask

   task automatic t_latch_commit();
      wr(4'd0, 32'd100);
      rd_chk("R3 latch read while idle", 4'd0, 32'd100);
      wr(A_CTRL, 32'h1);
      rd_chk("R4 commit on enable", 4'd0, 32'd100);
      pulse(8'h01, 5);
      rd_chk("R5 R11 live count", 4'd0, 32'd105);
      rd_chk("R5 other counter quiet", 4'd3, 32'd0);
      wr(4'd0, 32'd7);
      pulse(8'h01, 3);
      rd_chk("R3 pending hides live", 4'd0, 32'd7);
      wr(A_CTRL, 32'h1);
      rd_chk("R4 re-enable commits", 4'd0, 32'd7);
      pulse(8'h01, 2);
      rd_chk("R5 counting after commit", 4'd0, 32'd9);
   endtask

   task automatic t_stop();
      wr(A_CTRL, 32'h0);
      pulse(8'hFF, 4);
      rd_chk("R6 frozen when disabled", 4'd0, 32'd9);
   endtask

   task automatic t_wrap_full();
      wr(4'd2, 32'hFFFF_FFFE);
      wr(A_CTRL, 32'h1);
      pulse(8'h44, 3);
      rd_chk("R7 32-bit wrap", 4'd2, 32'd1);
      rd_chk("R10 upper logical reads zero", 4'd6, 32'd0);
      wr(4'd6, 32'h55);
      rd_chk("R10 ignored write", 4'd6, 32'd0);
      wr(A_CTRL, 32'h1);
      rd_chk("R10 ignored write not committed", 4'd2, 32'd1);
   endtask

   task automatic t_split();
      wr(A_CTRL, 32'h5);
      rd_chk("R2 ctrl readback", A_CTRL, 32'h5);
      wr(4'd1, 32'hFFFF);
      wr(4'd5, 32'hFFFE);
      wr(A_CTRL, 32'h5);
      rd_chk("R8 upper half loaded", 4'd1, 32'hFFFF);
      rd_chk("R8 lower half loaded", 4'd5, 32'hFFFE);
      pulse(8'h22, 2);
      rd_chk("R8 upper wraps alone", 4'd1, 32'h1);
      rd_chk("R8 lower wraps alone", 4'd5, 32'h0);
      wr(4'd5, 32'h1234);
      rd_chk("R9 other half kept", 4'd1, 32'h1);
      rd_chk("R9 own half written", 4'd5, 32'h1234);
      wr(A_CTRL, 32'h5);
      pulse(8'h02, 3);
      rd_chk("R8 upper counts independently", 4'd1, 32'h4);
      rd_chk("R8 lower unchanged", 4'd5, 32'h1234);
      wr(4'd1, 32'hABCD);
      rd_chk("R9 lower kept on upper write", 4'd5, 32'h1234);
      rd_chk("R9 upper written", 4'd1, 32'hABCD);
      rd_chk("R11 unrelated counter live", 4'd0, 32'd9);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_latch_commit();
      t_stop();
      t_wrap_full();
      t_split();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule